// File: doc/BRIEF.md
# Card Response Halfword Read Queue

This block sits between the serial response receiver of a memory-card host and the host's register bus. When the receiver has captured a complete command response, it pulses a valid strobe together with a response-kind code and the captured bit vector. The block turns that response into a short queue of 16-bit halfwords. The host drains the queue by reading one fixed address, and every read pops one entry.

Short responses (48 bits on the line) are delivered whole, as three halfwords with the most significant first. Software rebuilds the 32-bit card status from them as `(h0 << 24) | (h1 << 8) | (h2 >> 8)`. That formula only works if the frame is delivered with no shift, so the 32-bit field arrives as frame bits 39..8. Long responses (136 bits) lose their top eight framing bits. The remaining 128 bits are delivered as eight halfwords, most significant first, so that consecutive pairs form 32-bit words with the first read as the upper half.

Top module: `rsp_hw_fifo`

## Requirements
- R1: After reset the queue is empty and `rdData` reads 0.
- R2: A load with kind 1 (short, CRC-checked) queues exactly three halfwords, taken from `rspBits[47:32]`, `[31:16]` and `[15:0]` in that order. `(h0<<24)|(h1<<8)|(h2>>8)` over those three halfwords equals `rspBits[39:8]`.
- R3: A load with kind 2 (long) queues exactly eight halfwords, `rspBits[127:112]` first down to `rspBits[15:0]`. Bits 135..128 are never delivered.
- R4: A load with kind 0 (no response) leaves the queue empty, so `rdData` reads 0 from the next cycle.
- R5: A pop while the queue is empty has no effect. `rdData` stays 0, and a later load still delivers its first halfword first.
- R6: A new load discards any halfwords of the previous response that have not yet been read.
- R7: When a load and a pop arrive in the same cycle, the load wins and the pop is ignored. The first halfword of the new response is presented next.
- R8: `rdData` always shows the head entry, or 0 when the queue is empty. It advances by exactly one entry at each clock edge where `popReq` is high and changes at no other time except on a load.
- R9: A load with kind 3 (short, no CRC) behaves identically to kind 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rspValid | input | 1 | One-cycle strobe: a captured response is presented |
| rspKind | input | 2 | 0 none, 1 short with CRC, 2 long, 3 short without CRC |
| rspBits | input | 136 | Captured response, last received bit at bit 0 |
| popReq | input | 1 | Host read of the response address; pops the head entry |
| rdData | output | 16 | Head halfword, 0 when empty |

## Verification
The embedded assertions check several properties on every cycle:
- the entry count never exceeds the eight slots;
- each response kind sets the count it should;
- a pop on an empty queue leaves the count at zero;
- every pop moves the count down by exactly one and shifts the next slot to the head;
- a kind-0 load yields a zero read on the next cycle.

Other behaviour can only be shown by the bench scenarios, which compare against a queue model on every clock:
- the bit alignment of each halfword against the captured vector;
- the rebuilt short status word;
- flushing a half-read response;
- load-over-pop priority;
- dropping of the long frame's top byte.

// File: rtl/rsp_hw_fifo_pkg.sv
package rsp_hw_fifo_pkg;

  typedef enum logic [1:0] {
    RSP_NONE      = 2'd0,
    RSP_SHORT_CRC = 2'd1,
    RSP_LONG      = 2'd2,
    RSP_SHORT_RAW = 2'd3
  } rspKind_e;

  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic load;     // capture a new response into the slots
    logic advance;  // shift the slots one place towards the head
    logic longFmt;  // the response being loaded is the long format
    logic empty;    // no unread entry remains
  } fifoCtl_t;

endpackage

// File: rtl/rsp_hw_fifo_ctrl.sv
module rsp_hw_fifo_ctrl
  import rsp_hw_fifo_pkg::*;
#(
  parameter int SLOTS       = 8,
  parameter int SHORT_SLOTS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rspValid,
  input  logic [1:0] rspKind,
  input  logic       popReq,
  output fifoCtl_t   ctl
);

  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(SLOTS);
  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_SLOTS);

  logic [CNT_W-1:0] remain;
  rspKind_e         kind;

  assign kind = rspKind_e'(rspKind);

  always_comb begin
    ctl.load    = rspValid;
    ctl.longFmt = (kind == RSP_LONG);
    ctl.empty   = (remain == '0);
    ctl.advance = popReq && !rspValid && (remain != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (ctl.load) begin
      unique case (kind)
        RSP_NONE:                     remain <= '0;
        RSP_LONG:                     remain <= FULL_CNT;
        RSP_SHORT_CRC, RSP_SHORT_RAW: remain <= SHORT_CNT;
        default:                      remain <= '0;
      endcase
    end else if (ctl.advance) begin
      remain <= remain - 1'b1;
    end
  end

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    remain <= FULL_CNT);

  a_r2_short_count: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspKind == 2'd1 || rspKind == 2'd3)) |=> (remain == SHORT_CNT));

  a_r3_long_count: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 2'd2) |=> (remain == FULL_CNT));

  a_r5_empty_pop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !rspValid && remain == '0) |=> (remain == '0));

  a_r7_load_beats_pop: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && popReq && rspKind == 2'd2) |=> (remain == FULL_CNT));

  a_r8_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !rspValid && remain != '0) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/rsp_hw_fifo_data.sv
module rsp_hw_fifo_data
  import rsp_hw_fifo_pkg::*;
#(
  parameter int HW_W        = 16,
  parameter int SLOTS       = 8,
  parameter int SHORT_SLOTS = 3,
  parameter int FRAME_W     = 136
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifoCtl_t           ctl,
  input  logic [FRAME_W-1:0] rspBits,
  output logic [HW_W-1:0]    rdData
);

  localparam int LONG_TOP  = SLOTS * HW_W - 1;
  localparam int SHORT_TOP = SHORT_SLOTS * HW_W - 1;

  logic [HW_W-1:0] slot [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [HW_W-1:0] longHw;
    logic [HW_W-1:0] shortHw;
    logic [HW_W-1:0] nextHw;

    assign longHw = rspBits[LONG_TOP - g*HW_W -: HW_W];

    if (g < SHORT_SLOTS) begin : g_short
      assign shortHw = rspBits[SHORT_TOP - g*HW_W -: HW_W];
    end else begin : g_noshort
      assign shortHw = '0;
    end

    if (g == SLOTS - 1) begin : g_tail
      assign nextHw = '0;
    end else begin : g_body
      assign nextHw = slot[g+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slot[g] <= '0;
      end else if (ctl.load) begin
        slot[g] <= ctl.longFmt ? longHw : shortHw;
      end else if (ctl.advance) begin
        slot[g] <= nextHw;
      end
    end
  end

  assign rdData = ctl.empty ? '0 : slot[0];

  a_r8_shift_to_head: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.load) |=> (slot[0] == $past(slot[1])));

  a_r3_long_head: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.longFmt) |=> (slot[0] == $past(rspBits[LONG_TOP -: HW_W])));

endmodule

// File: rtl/rsp_hw_fifo.sv
module rsp_hw_fifo
  import rsp_hw_fifo_pkg::*;
#(
  parameter int HW_W        = 16,
  parameter int SLOTS       = 8,
  parameter int SHORT_SLOTS = 3,
  parameter int FRAME_W     = 136
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rspValid,
  input  logic [1:0]         rspKind,
  input  logic [FRAME_W-1:0] rspBits,
  input  logic               popReq,
  output logic [HW_W-1:0]    rdData
);

  fifoCtl_t ctl;

  rsp_hw_fifo_ctrl #(
    .SLOTS       (SLOTS),
    .SHORT_SLOTS (SHORT_SLOTS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .rspValid (rspValid),
    .rspKind  (rspKind),
    .popReq   (popReq),
    .ctl      (ctl)
  );

  rsp_hw_fifo_data #(
    .HW_W        (HW_W),
    .SLOTS       (SLOTS),
    .SHORT_SLOTS (SHORT_SLOTS),
    .FRAME_W     (FRAME_W)
  ) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .rspBits (rspBits),
    .rdData  (rdData)
  );

  a_r4_none_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 2'd0) |=> (rdData == '0));

endmodule

// File: tb/rsp_hw_fifo_tb_top.sv
module rsp_hw_fifo_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic         clk = 1'b0;
  logic         rstN;
  logic         rspValid;
  logic [1:0]   rspKind;
  logic [135:0] rspBits;
  logic         popReq;
  logic [15:0]  rdData;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rsp_hw_fifo dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .rspValid (rspValid),
    .rspKind  (rspKind),
    .rspBits  (rspBits),
    .popReq   (popReq),
    .rdData   (rdData)
  );

  function automatic logic [135:0] rand_bits();
    return {$urandom(), $urandom(), $urandom(), $urandom(), 8'($urandom())};
  endfunction

  task automatic check(string tag, logic [15:0] exp);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s: rdData=%h expected=%h", tag, rdData, exp);
    end
  endtask

  // Drive one cycle, update the queue model as of the next edge, check at negedge
  task automatic step(bit ld, logic [1:0] k, logic [135:0] b, bit pop, string tag);
    rspValid = ld;
    rspKind  = k;
    rspBits  = b;
    popReq   = pop;
    @(posedge clk);
    if (ld) begin
      model.delete();
      if (k == 2'd2) begin
        for (int i = 0; i < 8; i++) model.push_back(b[127 - 16*i -: 16]);
      end else if (k != 2'd0) begin
        for (int i = 0; i < 3; i++) model.push_back(b[47 - 16*i -: 16]);
      end
    end else if (pop && model.size() > 0) begin
      void'(model.pop_front());
    end
    @(negedge clk);
    rspValid = 1'b0;
    popReq   = 1'b0;
    check(tag, model.size() > 0 ? model[0] : 16'h0);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    errors++;
    $display("FAIL R8: watchdog expired, actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [135:0] b;
    logic [15:0]  h0, h1, h2;
    logic [31:0]  word;
    rstN = 1'b0; rspValid = 1'b0; rspKind = 2'd0; rspBits = '0; popReq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset", 16'h0);
    step(1'b0, 2'd0, '0, 1'b1, "R5 pop after reset");

    // R2: short with CRC, and the status word rebuild
    b = rand_bits();
    step(1'b1, 2'd1, b, 1'b0, "R2 short load");
    h0 = rdData;
    step(1'b0, 2'd0, '0, 1'b1, "R2 second");
    h1 = rdData;
    step(1'b0, 2'd0, '0, 1'b1, "R2 third");
    h2 = rdData;
    word = (32'(h0) << 24) | (32'(h1) << 8) | (32'(h2) >> 8);
    checks++;
    if (word !== b[39:8]) begin
      errors++;
      $display("FAIL R2 rebuild: actual=%h expected=%h", word, b[39:8]);
    end
    step(1'b0, 2'd0, '0, 1'b1, "R2 drained");
    step(1'b0, 2'd0, '0, 1'b1, "R5 pop on empty");

    // R9: short without CRC, same bits
    step(1'b1, 2'd3, b, 1'b0, "R9 raw short load");
    for (int i = 0; i < 4; i++) step(1'b0, 2'd0, '0, 1'b1, "R9 drain");

    // R3: long, top byte dropped
    b = rand_bits();
    b[135:128] = 8'hFF;
    step(1'b1, 2'd2, b, 1'b0, "R3 long load");
    for (int i = 0; i < 9; i++) step(1'b0, 2'd0, '0, 1'b1, "R3 long drain");

    // R6: flush a half-read long by a short
    step(1'b1, 2'd2, rand_bits(), 1'b0, "R6 long load");
    step(1'b0, 2'd0, '0, 1'b1, "R6 pop");
    step(1'b0, 2'd0, '0, 1'b1, "R6 pop");
    step(1'b1, 2'd1, rand_bits(), 1'b0, "R6 flush by short");
    for (int i = 0; i < 4; i++) step(1'b0, 2'd0, '0, 1'b1, "R6 drain");

    // R7: load and pop together
    step(1'b1, 2'd1, rand_bits(), 1'b0, "R7 first load");
    step(1'b1, 2'd2, rand_bits(), 1'b1, "R7 load with pop");
    step(1'b0, 2'd0, '0, 1'b1, "R7 next");

    // R4: kind none flushes
    step(1'b1, 2'd0, rand_bits(), 1'b0, "R4 none load");
    step(1'b0, 2'd0, '0, 1'b0, "R4 stays empty");

    // R8: holds without pop
    step(1'b1, 2'd2, rand_bits(), 1'b0, "R8 load");
    for (int i = 0; i < 3; i++) step(1'b0, 2'd0, '0, 1'b0, "R8 idle hold");

    // R8: random mix
    for (int i = 0; i < 200; i++) begin
      bit ld;
      ld = ($urandom_range(0, 5) == 0);
      step(ld, 2'($urandom()), rand_bits(), bit'($urandom()), "R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule